// File: doc/BRIEF.md
# Interrupt Distributor Register Block

This block holds the routing state for 256 interrupt lines on a four-core cluster. Each line has an enable bit, a pending bit, an 8-bit urgency value and a 4-bit core mask. Software programs this state through one register port. The port takes 32-bit accesses everywhere and byte accesses in the urgency and core-mask arrays. Rising edges on the peripheral lines (IDs 32 and up) latch as pending. A single encoded register write raises a software interrupt (IDs 0 to 15) and steers it to a chosen set of cores.

The whole state is exported as flat vectors for the downstream per-core logic. An optional arbiter reports, for each core, the most urgent interrupt that is enabled and pending and that targets that core. IDs 16 to 31 do not exist. Reads return zero from a location that holds nothing, and the port has no read strobe. Software names the requesting core on a dedicated input when it writes.

Top module: `irq_distributor`

## Requirements
- R1: After reset every enable bit, pending bit, urgency byte and core mask is zero, no software-interrupt pulse is driven and no core reports a winner.
- R2: IDs 16 to 31 have no state. Their enable and pending bits read as zero on the ports and on the bus, and writes to them have no effect.
- R3: A 32-bit write to 0x100 + 4w sets the enable of ID 32w+b for every bit b written as 1. Zero bits change nothing. A read of the word returns those enables.
- R4: A 32-bit write to 0x180 + 4w clears the enable of ID 32w+b for every 1 bit and leaves the enables of the 0 bits unchanged. A read of this word also returns the enables.
- R5: A 32-bit write to 0x200 + 4w sets the pending bit for each 1 bit. A write to 0x280 + 4w clears the pending bit for each 1 bit. Reads at either offset return the pending bits.
- R6: If irq_in[k] is low at one clock edge and high at the next, pending bit 32+k is set at that next edge. A line held high does not set the bit again after it is cleared. A rising edge wins over a clear of the same bit on the same edge.
- R7: The urgency of ID n is the byte at 0x400 + n. A 32-bit access at 0x400 + 4w covers IDs 4w to 4w+3, with ID 4w+k in bits [8k+7:8k]. A byte access reads or writes bits [7:0] only, and a smaller value means more urgent.
- R8: The core mask of ID n is the byte at 0x800 + n, with the same lane layout as R7. Only bits [3:0] are stored, and bits [7:4] of each lane read as zero.
- R9: A 32-bit write to 0xF00 carries the ID in bits [3:0], a core list in bits [19:16] and a filter in bits [25:24]. Filter 0 selects the listed cores. Filter 1 selects all cores except the requester (bus_cpu). Filter 2 selects only the requester. Filter 3 selects none. If any core is selected, sgi_fire_o shows the selection and sgi_id_o shows the ID for the one cycle after the write, and the ID's pending bit is set. Reads of 0xF00 return zero.
- R10: For each core c, best_valid_o[c] is high when some interrupt is enabled, pending and has mask bit c set. best_id_o[8c+7:8c] is then the qualifying ID with the smallest urgency value, and the lowest ID among equal values. The report follows the state registered at the previous clock edge.
- R11: Byte writes outside the urgency and core-mask arrays are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the current access |
| bus_byte | input | 1 | 1 = byte access, 0 = 32-bit access |
| bus_addr | input | 12 | Byte address within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| bus_cpu | input | 2 | Core issuing the access |
| irq_in | input | 224 | Peripheral lines; bit k drives ID 32+k |
| enable_o | output | 256 | Enable bit per ID |
| pending_o | output | 256 | Pending bit per ID |
| prio_o | output | 2048 | Urgency byte per ID, ID n at [8n+7:8n] |
| target_o | output | 1024 | Core mask per ID, ID n at [4n+3:4n] |
| sgi_fire_o | output | 4 | One-cycle per-core software-interrupt pulse |
| sgi_id_o | output | 4 | ID of the pulsed software interrupt |
| best_valid_o | output | 4 | A winner exists for core c |
| best_id_o | output | 32 | Winning ID for core c at [8c+7:8c] |

## Verification
Every register bit drives a port directly, so a corrupted enable, pending, urgency or mask bit shows on enable_o, pending_o, prio_o or target_o at the next sampling point after the write that caused it. The bench sweeps every ID through set and clear, and every word through both lane layouts, so one misrouted bit index or byte lane gives a mismatch within one cycle. Errors in the arbiter stay hidden until two candidates compete. The bench therefore builds urgency ties, masked cores and disabled-but-pending lines, and reads the per-core winners after each change.

// File: rtl/dist_pkg.sv
package dist_pkg;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_EN_SET,
        RGN_EN_CLR,
        RGN_PD_SET,
        RGN_PD_CLR,
        RGN_PRIO,
        RGN_TGT,
        RGN_SGI
    } region_e;

    localparam logic [11:0] SGI_ADDR = 12'hF00;

    function automatic region_e decode_region(input logic [11:0] a);
        region_e r;
        r = RGN_NONE;
        if (a[11:7] == 5'h02)       r = RGN_EN_SET;
        else if (a[11:7] == 5'h03)  r = RGN_EN_CLR;
        else if (a[11:7] == 5'h04)  r = RGN_PD_SET;
        else if (a[11:7] == 5'h05)  r = RGN_PD_CLR;
        else if (a[11:10] == 2'b01) r = RGN_PRIO;
        else if (a[11:10] == 2'b10) r = RGN_TGT;
        else if (a == SGI_ADDR)     r = RGN_SGI;
        return r;
    endfunction

endpackage

// File: rtl/dist_regs.sv
module dist_regs
    import dist_pkg::*;
#(
    parameter int NUM_IRQ = 256,
    parameter int NUM_CPU = 4,
    parameter int PRIO_W  = 8,
    localparam int CPU_W  = $clog2(NUM_CPU),
    localparam int NUM_PER = NUM_IRQ - 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        wr_byte,
    input  logic [11:0]                 wr_addr,
    input  logic [31:0]                 wr_data,
    input  logic [CPU_W-1:0]            wr_cpu,
    input  logic [NUM_PER-1:0]          irq_in,
    output logic [NUM_IRQ-1:0]          en_o,
    output logic [NUM_IRQ-1:0]          pend_o,
    output logic [NUM_IRQ*PRIO_W-1:0]   prio_o,
    output logic [NUM_IRQ*NUM_CPU-1:0]  tgt_o,
    output logic [NUM_CPU-1:0]          sgi_fire_o,
    output logic [3:0]                  sgi_id_o
);

    localparam logic [NUM_IRQ-1:0] GAP  = {{NUM_PER{1'b0}}, 16'hFFFF, 16'h0000};
    localparam logic [NUM_IRQ-1:0] IMPL = ~GAP;

    typedef struct packed {
        logic [NUM_IRQ-1:0]              en;
        logic [NUM_IRQ-1:0]              pend;
        logic [NUM_IRQ-1:0][PRIO_W-1:0]  prio;
        logic [NUM_IRQ-1:0][NUM_CPU-1:0] tgt;
        logic [NUM_PER-1:0]              line_last;
        logic [NUM_CPU-1:0]              sgi_fire;
        logic [3:0]                      sgi_id;
    } state_t;

    state_t s_d, s_q;
    region_e rgn;
    logic [7:0] lane_v;
    logic [NUM_CPU-1:0] self_oh, sgi_mask;

    always_comb begin
        s_d          = s_q;
        s_d.sgi_fire = '0;
        rgn          = decode_region(wr_addr);
        lane_v       = '0;
        self_oh      = '0;
        self_oh[wr_cpu] = 1'b1;
        sgi_mask     = '0;

        for (int i = 0; i < NUM_IRQ; i++) begin
            if (wr_en && !wr_byte && (int'(wr_addr[6:2]) == i / 32) && wr_data[i % 32]) begin
                case (rgn)
                    RGN_EN_SET: s_d.en[i]   = 1'b1;
                    RGN_EN_CLR: s_d.en[i]   = 1'b0;
                    RGN_PD_SET: s_d.pend[i] = 1'b1;
                    RGN_PD_CLR: s_d.pend[i] = 1'b0;
                    default: ;
                endcase
            end
            if (wr_en && (wr_byte ? (int'(wr_addr[9:0]) == i) : (int'(wr_addr[9:2]) == i / 4))) begin
                lane_v = wr_byte ? wr_data[7:0] : wr_data[8*(i%4) +: 8];
                if (rgn == RGN_PRIO) s_d.prio[i] = lane_v[PRIO_W-1:0];
                if (rgn == RGN_TGT)  s_d.tgt[i]  = lane_v[NUM_CPU-1:0];
            end
        end

        if (wr_en && !wr_byte && rgn == RGN_SGI) begin
            case (wr_data[25:24])
                2'd0:    sgi_mask = wr_data[16 +: NUM_CPU];
                2'd1:    sgi_mask = ~self_oh;
                2'd2:    sgi_mask = self_oh;
                default: sgi_mask = '0;
            endcase
            if (|sgi_mask) begin
                s_d.sgi_fire                     = sgi_mask;
                s_d.sgi_id                       = wr_data[3:0];
                s_d.pend[int'(wr_data[3:0])]     = 1'b1;
            end
        end

        // peripheral edges are applied last so they win over a clear
        s_d.line_last = irq_in;
        for (int k = 0; k < NUM_PER; k++) begin
            if (irq_in[k] && !s_q.line_last[k]) s_d.pend[32 + k] = 1'b1;
        end

        s_d.en   = s_d.en & IMPL;
        s_d.pend = s_d.pend & IMPL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en_o       = s_q.en;
    assign pend_o     = s_q.pend;
    assign prio_o     = s_q.prio;
    assign tgt_o      = s_q.tgt;
    assign sgi_fire_o = s_q.sgi_fire;
    assign sgi_id_o   = s_q.sgi_id;

endmodule

// File: rtl/dist_readmux.sv
module dist_readmux
    import dist_pkg::*;
#(
    parameter int NUM_IRQ = 256,
    parameter int NUM_CPU = 4,
    parameter int PRIO_W  = 8
) (
    input  logic [11:0]                 rd_addr,
    input  logic                        rd_byte,
    input  logic [NUM_IRQ-1:0]          en,
    input  logic [NUM_IRQ-1:0]          pend,
    input  logic [NUM_IRQ*PRIO_W-1:0]   prio,
    input  logic [NUM_IRQ*NUM_CPU-1:0]  tgt,
    output logic [31:0]                 rdata
);

    region_e rgn;
    int      lane;

    always_comb begin
        rdata = '0;
        rgn   = decode_region(rd_addr);
        lane  = 0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (!rd_byte && (int'(rd_addr[6:2]) == i / 32)) begin
                if (rgn == RGN_EN_SET || rgn == RGN_EN_CLR) rdata[i % 32] = en[i];
                if (rgn == RGN_PD_SET || rgn == RGN_PD_CLR) rdata[i % 32] = pend[i];
            end
            if (rd_byte ? (int'(rd_addr[9:0]) == i) : (int'(rd_addr[9:2]) == i / 4)) begin
                lane = rd_byte ? 0 : 8 * (i % 4);
                if (rgn == RGN_PRIO) rdata[lane +: 8] = 8'(prio[i*PRIO_W +: PRIO_W]);
                if (rgn == RGN_TGT)  rdata[lane +: 8] = 8'(tgt[i*NUM_CPU +: NUM_CPU]);
            end
        end
    end

endmodule

// File: rtl/dist_arbiter.sv
module dist_arbiter #(
    parameter int NUM_IRQ = 256,
    parameter int NUM_CPU = 4,
    parameter int PRIO_W  = 8,
    parameter bit HAS_ARB = 1'b1,
    localparam int IDW    = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0]          en,
    input  logic [NUM_IRQ-1:0]          pend,
    input  logic [NUM_IRQ*PRIO_W-1:0]   prio,
    input  logic [NUM_IRQ*NUM_CPU-1:0]  tgt,
    output logic [NUM_CPU-1:0]          best_valid,
    output logic [NUM_CPU*IDW-1:0]      best_id
);

    generate
        if (HAS_ARB) begin : g_arb
            for (genvar c = 0; c < NUM_CPU; c++) begin : g_core
                logic              found;
                logic [PRIO_W-1:0] bp;
                logic [IDW-1:0]    bi;
                always_comb begin
                    found = 1'b0;
                    bp    = '1;
                    bi    = '0;
                    // ascending scan with strict compare keeps the lowest ID on ties
                    for (int i = 0; i < NUM_IRQ; i++) begin
                        if (en[i] && pend[i] && tgt[i*NUM_CPU + c] &&
                            (!found || prio[i*PRIO_W +: PRIO_W] < bp)) begin
                            found = 1'b1;
                            bp    = prio[i*PRIO_W +: PRIO_W];
                            bi    = IDW'(i);
                        end
                    end
                end
                assign best_valid[c]          = found;
                assign best_id[c*IDW +: IDW]  = bi;
            end
        end else begin : g_none
            assign best_valid = '0;
            assign best_id    = '0;
        end
    endgenerate

endmodule

// File: rtl/irq_distributor.sv
module irq_distributor #(
    parameter int NUM_IRQ = 256,
    parameter int NUM_CPU = 4,
    parameter int PRIO_W  = 8,
    parameter bit HAS_ARB = 1'b1,
    localparam int CPU_W  = $clog2(NUM_CPU),
    localparam int IDW    = $clog2(NUM_IRQ),
    localparam int NUM_PER = NUM_IRQ - 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_we,
    input  logic                        bus_byte,
    input  logic [11:0]                 bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    input  logic [CPU_W-1:0]            bus_cpu,
    input  logic [NUM_PER-1:0]          irq_in,
    output logic [NUM_IRQ-1:0]          enable_o,
    output logic [NUM_IRQ-1:0]          pending_o,
    output logic [NUM_IRQ*PRIO_W-1:0]   prio_o,
    output logic [NUM_IRQ*NUM_CPU-1:0]  target_o,
    output logic [NUM_CPU-1:0]          sgi_fire_o,
    output logic [3:0]                  sgi_id_o,
    output logic [NUM_CPU-1:0]          best_valid_o,
    output logic [NUM_CPU*IDW-1:0]      best_id_o
);

    dist_regs #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .PRIO_W(PRIO_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_we),
        .wr_byte    (bus_byte),
        .wr_addr    (bus_addr),
        .wr_data    (bus_wdata),
        .wr_cpu     (bus_cpu),
        .irq_in     (irq_in),
        .en_o       (enable_o),
        .pend_o     (pending_o),
        .prio_o     (prio_o),
        .tgt_o      (target_o),
        .sgi_fire_o (sgi_fire_o),
        .sgi_id_o   (sgi_id_o)
    );

    dist_readmux #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .PRIO_W(PRIO_W)) u_rd (
        .rd_addr (bus_addr),
        .rd_byte (bus_byte),
        .en      (enable_o),
        .pend    (pending_o),
        .prio    (prio_o),
        .tgt     (target_o),
        .rdata   (bus_rdata)
    );

    dist_arbiter #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .PRIO_W(PRIO_W), .HAS_ARB(HAS_ARB)) u_arb (
        .en         (enable_o),
        .pend       (pending_o),
        .prio       (prio_o),
        .tgt        (target_o),
        .best_valid (best_valid_o),
        .best_id    (best_id_o)
    );

endmodule

// File: rtl/irq_distributor_chk.sv
module irq_distributor_chk #(
    parameter int NUM_IRQ = 256,
    parameter int NUM_CPU = 4,
    parameter int PRIO_W  = 8,
    localparam int CPU_W  = $clog2(NUM_CPU),
    localparam int IDW    = $clog2(NUM_IRQ),
    localparam int NUM_PER = NUM_IRQ - 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_we,
    input logic                        bus_byte,
    input logic [11:0]                 bus_addr,
    input logic [31:0]                 bus_wdata,
    input logic [NUM_PER-1:0]          irq_in,
    input logic [NUM_IRQ-1:0]          enable_o,
    input logic [NUM_IRQ-1:0]          pending_o,
    input logic [NUM_IRQ*NUM_CPU-1:0]  target_o,
    input logic [NUM_CPU-1:0]          sgi_fire_o,
    input logic [3:0]                  sgi_id_o,
    input logic [NUM_CPU-1:0]          best_valid_o,
    input logic [NUM_CPU*IDW-1:0]      best_id_o
);

    logic [IDW-1:0] win0;
    assign win0 = best_id_o[IDW-1:0];

    AST_GAP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_o[31:16] == 16'h0) && (pending_o[31:16] == 16'h0)); // R2

    AST_SET_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_byte && bus_addr == 12'h104 && bus_wdata[0]) |=> enable_o[32]); // R3

    AST_CLR_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_byte && bus_addr == 12'h184 && bus_wdata[0]) |=> !enable_o[32]); // R4

    AST_CLR_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_byte && bus_addr == 12'h280 && bus_wdata[0]) |=> !pending_o[0]); // R5

    AST_EDGE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_in[0]) |=> pending_o[32]); // R6

    AST_SGI_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (|sgi_fire_o) |-> pending_o[sgi_id_o]); // R9

    AST_SGI_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_byte && bus_addr == 12'hF00 && bus_wdata[25:24] == 2'b11) |=> (sgi_fire_o == '0)); // R9

    AST_WIN_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        best_valid_o[0] |-> (enable_o[win0] && pending_o[win0] && target_o[int'(win0)*NUM_CPU])); // R10

endmodule

bind irq_distributor irq_distributor_chk #(
    .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .PRIO_W(PRIO_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_we       (bus_we),
    .bus_byte     (bus_byte),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .irq_in       (irq_in),
    .enable_o     (enable_o),
    .pending_o    (pending_o),
    .target_o     (target_o),
    .sgi_fire_o   (sgi_fire_o),
    .sgi_id_o     (sgi_id_o),
    .best_valid_o (best_valid_o),
    .best_id_o    (best_id_o)
);

// File: tb/tb_irq_distributor.sv
`timescale 1ns/1ps
module tb_irq_distributor;

    localparam int N  = 256;
    localparam int NC = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic              bus_byte = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [1:0]        bus_cpu = '0;
    logic [N-33:0]     irq_in = '0;
    logic [N-1:0]      enable_o, pending_o;
    logic [N*8-1:0]    prio_o;
    logic [N*NC-1:0]   target_o;
    logic [NC-1:0]     sgi_fire_o;
    logic [3:0]        sgi_id_o;
    logic [NC-1:0]     best_valid_o;
    logic [NC*8-1:0]   best_id_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_distributor dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_byte(bus_byte),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_cpu(bus_cpu), .irq_in(irq_in), .enable_o(enable_o),
        .pending_o(pending_o), .prio_o(prio_o), .target_o(target_o),
        .sgi_fire_o(sgi_fire_o), .sgi_id_o(sgi_id_o),
        .best_valid_o(best_valid_o), .best_id_o(best_id_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic by, input logic [1:0] cpu);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_byte = by; bus_cpu = cpu;
        @(negedge clk);
        bus_we = 1'b0; bus_byte = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic by, output logic [31:0] d);
        bus_addr = a; bus_byte = by;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [7:0] pat_p(input int id);
        return 8'((id * 37 + 11) & 255);
    endfunction

    function automatic logic [3:0] pat_t(input int id);
        return 4'((id * 5 + 1) & 15);
    endfunction

    function automatic bit in_gap(input int id);
        return (id >= 16 && id < 32);
    endfunction

    initial begin
        #(8 * 190000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state through bus and ports
        for (int w = 0; w < 8; w++) begin
            rd(12'(12'h100 + 4*w), 1'b0, d); check("R1 enable word", d, 0);
            rd(12'(12'h200 + 4*w), 1'b0, d); check("R1 pending word", d, 0);
        end
        for (int w = 0; w < 64; w++) begin
            rd(12'(12'h400 + 4*w), 1'b0, d); check("R1 prio word", d, 0);
            rd(12'(12'h800 + 4*w), 1'b0, d); check("R1 target word", d, 0);
        end
        check("R1 sgi pulse", 32'(sgi_fire_o), 0);
        check("R1 winners", 32'(best_valid_o), 0);

        // R3 R4 R2: per-ID enable sweep
        for (int id = 0; id < N; id++) begin
            wr(12'(12'h100 + (id/32)*4), 32'(1) << (id % 32), 1'b0, 2'd0);
            check("R3/R2 set enable", 32'(enable_o[id]), in_gap(id) ? 0 : 1);
            wr(12'(12'h180 + (id/32)*4), 32'(1) << (id % 32), 1'b0, 2'd0);
            check("R4 clear enable", 32'(enable_o[id]), 0);
        end
        for (int w = 0; w < 8; w++) wr(12'(12'h100 + 4*w), 32'hFFFF_FFFF, 1'b0, 2'd0);
        rd(12'h100, 1'b0, d); check("R2 gap reads zero", d, 32'h0000_FFFF);
        rd(12'h184, 1'b0, d); check("R4 clear array reads enables", d, 32'hFFFF_FFFF);
        wr(12'h104, 32'h0, 1'b0, 2'd0);
        rd(12'h104, 1'b0, d); check("R3 zero write no effect", d, 32'hFFFF_FFFF);
        wr(12'h184, 32'h0000_00F0, 1'b0, 2'd0);
        rd(12'h104, 1'b0, d); check("R4 clear selected bits only", d, 32'hFFFF_FF0F);
        wr(12'h188, 32'hFF, 1'b1, 2'd0);
        rd(12'h108, 1'b0, d); check("R11 byte write to clear array ignored", d, 32'hFFFF_FFFF);
        for (int w = 0; w < 8; w++) wr(12'(12'h180 + 4*w), 32'hFFFF_FFFF, 1'b0, 2'd0);
        check("R4 all cleared", 32'(|enable_o), 0);

        // R5 R2: per-ID pending sweep
        for (int id = 0; id < N; id++) begin
            wr(12'(12'h200 + (id/32)*4), 32'(1) << (id % 32), 1'b0, 2'd0);
            check("R5/R2 set pending", 32'(pending_o[id]), in_gap(id) ? 0 : 1);
            rd(12'(12'h280 + (id/32)*4), 1'b0, d);
            check("R5 pending readback", d, in_gap(id) ? 0 : (32'(1) << (id % 32)));
            wr(12'(12'h280 + (id/32)*4), 32'(1) << (id % 32), 1'b0, 2'd0);
            check("R5 clear pending", 32'(pending_o[id]), 0);
        end
        wr(12'h204, 32'hFFFF_FFFF, 1'b1, 2'd0);
        check("R11 byte write to set-pending ignored", 32'(|pending_o), 0);

        // R6: edge capture per peripheral line
        for (int k = 0; k < N - 32; k++) begin
            @(negedge clk); irq_in[k] = 1'b1;
            @(negedge clk);
            check("R6 edge sets pending", 32'(pending_o[32+k]), 1);
            wr(12'(12'h280 + ((32+k)/32)*4), 32'(1) << ((32+k) % 32), 1'b0, 2'd0);
            @(negedge clk);
            check("R6 held level no re-set", 32'(pending_o[32+k]), 0);
            irq_in[k] = 1'b0;
        end
        @(negedge clk);
        irq_in[0] = 1'b1; bus_we = 1'b1; bus_byte = 1'b0; bus_addr = 12'h284; bus_wdata = 32'h1;
        @(negedge clk);
        bus_we = 1'b0;
        check("R6 edge beats clear", 32'(pending_o[32]), 1);
        irq_in[0] = 1'b0;
        wr(12'h284, 32'h1, 1'b0, 2'd0);
        check("R6 cleared afterwards", 32'(pending_o[32]), 0);

        // R7: urgency word writes, word and byte readback
        for (int w = 0; w < 64; w++)
            wr(12'(12'h400 + 4*w), {pat_p(4*w+3), pat_p(4*w+2), pat_p(4*w+1), pat_p(4*w)}, 1'b0, 2'd0);
        for (int id = 0; id < N; id++) begin
            check("R7 prio port", 32'(prio_o[id*8 +: 8]), 32'(pat_p(id)));
            rd(12'(12'h400 + id), 1'b1, d);
            check("R7 prio byte read", d, 32'(pat_p(id)));
        end
        rd(12'h414, 1'b0, d);
        check("R7 prio word read", d, {pat_p(23), pat_p(22), pat_p(21), pat_p(20)});
        wr(12'h405, 32'h1234_56AB, 1'b1, 2'd0);
        rd(12'h404, 1'b0, d);
        check("R7 byte write one lane", d, {pat_p(7), pat_p(6), 8'hAB, pat_p(4)});

        // R8: core masks, upper nibble dropped
        for (int w = 0; w < 64; w++)
            wr(12'(12'h800 + 4*w), {4'hA, pat_t(4*w+3), 4'h5, pat_t(4*w+2), 4'hC, pat_t(4*w+1), 4'h3, pat_t(4*w)}, 1'b0, 2'd0);
        for (int id = 0; id < N; id++)
            check("R8 target port", 32'(target_o[id*NC +: NC]), 32'(pat_t(id)));
        rd(12'h808, 1'b0, d);
        check("R8 target word read", d, {4'h0, pat_t(11), 4'h0, pat_t(10), 4'h0, pat_t(9), 4'h0, pat_t(8)});
        wr(12'h803, 32'hFF, 1'b1, 2'd0);
        rd(12'h803, 1'b1, d);
        check("R8 byte write keeps 4 bits", d, 32'h0F);

        // R9: software interrupt filter sweep
        for (int f = 0; f < 4; f++) begin
            for (int c = 0; c < NC; c++) begin
                int sid;
                logic [3:0] m;
                sid = (f * 4 + c) & 15;
                case (f)
                    0: m = 4'h5;
                    1: m = 4'hF & ~(4'h1 << c);
                    2: m = 4'h1 << c;
                    default: m = 4'h0;
                endcase
                wr(12'hF00, {6'h0, 2'(f), 8'hF5, 12'h0, 4'(sid)}, 1'b0, 2'(c));
                check("R9 sgi cores", 32'(sgi_fire_o), 32'(m));
                if (m != 0) check("R9 sgi id", 32'(sgi_id_o), 32'(sid));
                check("R9 sgi pending", 32'(pending_o[sid]), (m != 0) ? 1 : 0);
                rd(12'hF00, 1'b0, d);
                check("R9 sgi reads zero", d, 0);
                wr(12'h280, 32'hFFFF, 1'b0, 2'd0);
                check("R9 pulse one cycle", 32'(sgi_fire_o), 0);
            end
        end

        // R10: per-core winner selection
        for (int w = 0; w < 64; w++) begin
            wr(12'(12'h400 + 4*w), 32'hFFFF_FFFF, 1'b0, 2'd0);
            wr(12'(12'h800 + 4*w), 32'h0, 1'b0, 2'd0);
        end
        wr(12'h428, 32'h20, 1'b1, 2'd0); wr(12'h828, 32'h3, 1'b1, 2'd0); // ID 40
        wr(12'h429, 32'h10, 1'b1, 2'd0); wr(12'h829, 32'h1, 1'b1, 2'd0); // ID 41
        wr(12'h446, 32'h10, 1'b1, 2'd0); wr(12'h846, 32'h1, 1'b1, 2'd0); // ID 70
        wr(12'h464, 32'h05, 1'b1, 2'd0); wr(12'h864, 32'h4, 1'b1, 2'd0); // ID 100
        wr(12'h465, 32'h30, 1'b1, 2'd0); wr(12'h865, 32'h4, 1'b1, 2'd0); // ID 101
        check("R10 nothing pending", 32'(best_valid_o), 0);
        wr(12'h104, 32'h0000_0300, 1'b0, 2'd0);
        wr(12'h108, 32'h0000_0040, 1'b0, 2'd0);
        wr(12'h10C, 32'h0000_0020, 1'b0, 2'd0);
        wr(12'h204, 32'h0000_0300, 1'b0, 2'd0);
        wr(12'h208, 32'h0000_0040, 1'b0, 2'd0);
        wr(12'h20C, 32'h0000_0030, 1'b0, 2'd0);
        check("R10 valid cores", 32'(best_valid_o), 32'h7);
        check("R10 core0 tie lowest id", 32'(best_id_o[7:0]), 41);
        check("R10 core1 mask", 32'(best_id_o[15:8]), 40);
        check("R10 core2 skips disabled", 32'(best_id_o[23:16]), 101);
        wr(12'h284, 32'h0000_0200, 1'b0, 2'd0);
        check("R10 core0 after clear 41", 32'(best_id_o[7:0]), 70);
        wr(12'h288, 32'h0000_0040, 1'b0, 2'd0);
        check("R10 core0 after clear 70", 32'(best_id_o[7:0]), 40);
        wr(12'h4FF, 32'h00, 1'b1, 2'd0); wr(12'h8FF, 32'h8, 1'b1, 2'd0); // ID 255
        wr(12'h11C, 32'h8000_0000, 1'b0, 2'd0);
        wr(12'h21C, 32'h8000_0000, 1'b0, 2'd0);
        check("R10 core3 highest id", 32'(best_valid_o), 32'hF);
        check("R10 core3 id 255", 32'(best_id_o[31:24]), 255);
        wr(12'h180, 32'h0, 1'b0, 2'd0);
        for (int w = 0; w < 8; w++) wr(12'(12'h180 + 4*w), 32'hFFFF_FFFF, 1'b0, 2'd0);
        e = 0;
        check("R10 no winner when disabled", 32'(best_valid_o), e);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule